// File: doc/BRIEF.md
# Three-Channel Watchdog Timer with Bite and Bark Compares

This peripheral holds three watchdog channels behind a plain 32-bit register bus (address, write enable, write data, combinational read data). Each channel owns a counter that advances by one on every pulse of a reference tick input and that software may overwrite at any time. Servicing a channel means writing a small value into its counter. Each channel also owns a bite threshold and a control register. When the channel's reset enable is set and the counter is at or above the bite threshold, the channel raises a reset request.

The channels differ. Channel 0 alone has a second threshold, the bark threshold. When its interrupt enable is set and the counter reaches the bark value, a sticky status bit is set, and software clears it by writing one. The interrupt output is that status bit gated by the enable. A bite on channel 0 asks for a recovery-mode reset on its own output. Bites on channels 1 and 2 share the normal system reset output.

Each channel is run by a three-state machine. In OFF the reset enable is clear. In WATCH the channel is enabled and the counter is below the bite value. In BITE the channel is enabled and the counter is at or above the bite value. The named transitions are: arm (OFF to WATCH, or OFF to BITE when the threshold is already met), expire (WATCH to BITE), service (BITE to WATCH, after the counter is rewritten below the threshold), and disarm (WATCH or BITE to OFF). The reset request is high only in BITE.

Top module: `wdt_triple`

## Requirements
- R1: After the asynchronous active-low reset, every counter, threshold and control bit reads zero, and all three outputs are low.
- R2: A channel counter rises by exactly one on each cycle with the tick input high and holds in every other cycle. Above 0xFFFFFFFF it wraps to 0.
- R3: A bus write to a counter in the same cycle as a tick stores the written value. The tick increment is lost.
- R4: One cycle after a channel has reset enable (control bit 2) set and counter >= bite value, its request is high. Channel 0 drives the recovery reset output. Channels 1 and 2 drive the system reset output.
- R5: Writing zero to a control register drops that channel's request one cycle later. The counter keeps its value and keeps counting.
- R6: Setting reset enable, then writing bite value 0, then writing counter 0 gives a reset request, because 0 >= 0.
- R7: One cycle after channel 0 has interrupt enable (control bit 0) set and counter >= bark value, its status (control bit 1) is set. The status stays set until cleared. The interrupt output equals status AND interrupt enable.
- R8: Writing a control word with bit 1 set clears channel 0's status unless the bark condition still holds. Writing bit 1 as zero leaves the status as it was.
- R9: Register map, word offsets. Channel 0 has counter 0x00, bite 0x04, bark 0x08 and control 0x0C. Channel 1 has 0x10, 0x14 and 0x1C. Channel 2 has 0x20, 0x24 and 0x2C. Reads return current values. Control bits 0 and 1 of channels 1 and 2 always read zero.
- R10: Reads of any other offset (including 0x18, 0x28, 0x30 and unaligned addresses) return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick, one-cycle enable for all counters |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Channel 0 bark interrupt |
| rst_recovery_o | output | 1 | Channel 0 bite request (recovery reset) |
| rst_system_o | output | 1 | Bite request from channel 1 or 2 (system reset) |

## Verification
A register write or a tick takes effect at the clock edge where it is presented, so read data already shows it at the next falling edge. The reset requests and the bark status come from registers that sample the counters and thresholds, so they appear one edge after the condition becomes true, which is two edges after the write or tick that caused it. Each scenario task drives on the falling edge and leaves one idle edge before it samples a request, an interrupt or a status bit. Counter and threshold values are read back right after the writing edge. Before each boundary crossing of the >= compares, the tasks check the state one step below the threshold, so a strict compare or a late request shows up as a failure.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register field selected by address bits [3:2] inside a channel window
    typedef enum logic [1:0] {
        FLD_CUR  = 2'd0,
        FLD_BITE = 2'd1,
        FLD_BARK = 2'd2,
        FLD_CTRL = 2'd3
    } fld_e;

    // Per-channel watchdog state
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_WATCH = 2'd1,
        CH_BITE  = 2'd2
    } ch_state_e;

    // Control word bit positions
    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_IRQ_ST = 1;
    localparam int CTL_RST_EN = 2;

    // Each channel occupies a 16-byte window
    localparam int CH_WIN_LSB = 4;

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 3,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [CHW-1:0]    ch_o,
    output fld_e              fld_o
);

    localparam int TOP_LSB = CH_WIN_LSB + CHW;

    logic aligned;
    logic upper_zero;
    logic ch_ok;
    logic fld_ok;

    always_comb begin
        ch_o       = addr_i[CH_WIN_LSB +: CHW];
        fld_o      = fld_e'(addr_i[3:2]);
        aligned    = (addr_i[1:0] == 2'b00);
        upper_zero = ((addr_i >> TOP_LSB) == '0);
        ch_ok      = (int'(ch_o) < NUM_CH);
        // only channel 0 implements the bark threshold
        fld_ok     = (fld_o != FLD_BARK) || (ch_o == '0);
        hit_o      = aligned && upper_zero && ch_ok && fld_ok;
    end

endmodule

// File: rtl/wdt_chan.sv
module wdt_chan
    import wdt_pkg::*;
#(
    parameter int DW       = 32,
    parameter bit HAS_BARK = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_cur_i,
    input  logic          wr_bite_i,
    input  logic          wr_bark_i,
    input  logic          wr_ctrl_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cur_o,
    output logic [DW-1:0] bite_o,
    output logic [DW-1:0] bark_o,
    output logic [DW-1:0] ctrl_o,
    output logic          rst_req_o,
    output logic          irq_o
);

    logic [DW-1:0] cur_q;
    logic [DW-1:0] bite_q;
    logic [DW-1:0] bark_q;
    logic          rst_en_q;
    logic          irq_en_q;
    logic          irq_st_q;
    logic          bite_hit;
    ch_state_e     state_q;
    ch_state_e     state_d;

    // counter: bus write wins over the tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (wr_cur_i) begin
            cur_q <= wdata_i;
        end else if (tick_i) begin
            cur_q <= cur_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bite_q   <= '0;
            rst_en_q <= 1'b0;
        end else begin
            if (wr_bite_i) bite_q <= wdata_i;
            if (wr_ctrl_i) rst_en_q <= wdata_i[CTL_RST_EN];
        end
    end

    assign bite_hit = (cur_q >= bite_q);

    generate
        if (HAS_BARK) begin : g_bark
            logic bark_hit;
            logic st_clr;

            assign bark_hit = irq_en_q && (cur_q >= bark_q);
            assign st_clr   = wr_ctrl_i && wdata_i[CTL_IRQ_ST];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bark_q   <= '0;
                    irq_en_q <= 1'b0;
                    irq_st_q <= 1'b0;
                end else begin
                    if (wr_bark_i) bark_q <= wdata_i;
                    if (wr_ctrl_i) irq_en_q <= wdata_i[CTL_IRQ_EN];
                    irq_st_q <= (irq_st_q && !st_clr) || bark_hit;
                end
            end

            a_r7_bark_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_en_q && (cur_q >= bark_q)) |=> irq_st_q);
            a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_st_q && !(wr_ctrl_i && wdata_i[CTL_IRQ_ST])) |=> irq_st_q);
            a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_ctrl_i && wdata_i[CTL_IRQ_ST] && !(irq_en_q && (cur_q >= bark_q)))
                |=> !irq_st_q);
        end else begin : g_nobark
            logic unused_bark;
            assign unused_bark = wr_bark_i;
            assign bark_q   = '0;
            assign irq_en_q = 1'b0;
            assign irq_st_q = 1'b0;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, expire, service, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (rst_en_q) state_d = bite_hit ? CH_BITE : CH_WATCH;
            end
            CH_WATCH: begin
                if (!rst_en_q)    state_d = CH_OFF;
                else if (bite_hit) state_d = CH_BITE;
            end
            CH_BITE: begin
                if (!rst_en_q)     state_d = CH_OFF;
                else if (!bite_hit) state_d = CH_WATCH;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // outputs
    always_comb begin
        rst_req_o = 1'b0;
        unique case (state_q)
            CH_BITE:          rst_req_o = 1'b1;
            CH_OFF, CH_WATCH: rst_req_o = 1'b0;
            default:          rst_req_o = 1'b0;
        endcase
        irq_o  = irq_st_q && irq_en_q;
        ctrl_o = '0;
        ctrl_o[CTL_IRQ_EN] = irq_en_q;
        ctrl_o[CTL_IRQ_ST] = irq_st_q;
        ctrl_o[CTL_RST_EN] = rst_en_q;
        cur_o  = cur_q;
        bite_o = bite_q;
        bark_o = bark_q;
    end

    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cur_i) |=> (cur_q == DW'($past(cur_q) + 1'b1)));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_cur_i) |=> $stable(cur_q));
    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur_i |=> (cur_q == $past(wdata_i)));
    a_r4_bite_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_en_q && (cur_q >= bite_q)) |=> rst_req_o);
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_en_q |=> !rst_req_o);

endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux
    import wdt_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NUM_CH = 3,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     hit_i,
    input  logic [CHW-1:0]           ch_i,
    input  fld_e                     fld_i,
    input  logic [NUM_CH-1:0][DW-1:0] cur_i,
    input  logic [NUM_CH-1:0][DW-1:0] bite_i,
    input  logic [NUM_CH-1:0][DW-1:0] bark_i,
    input  logic [NUM_CH-1:0][DW-1:0] ctrl_i,
    output logic [DW-1:0]            rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (hit_i) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_i == CHW'(i)) begin
                    unique case (fld_i)
                        FLD_CUR:  rdata_o = cur_i[i];
                        FLD_BITE: rdata_o = bite_i[i];
                        FLD_BARK: rdata_o = bark_i[i];
                        FLD_CTRL: rdata_o = ctrl_i[i];
                        default:  rdata_o = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/wdt_triple.sv
module wdt_triple
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 3,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              rst_recovery_o,
    output logic              rst_system_o
);

    logic                         hit;
    logic [CHW-1:0]               ch_sel;
    fld_e                         fld_sel;
    logic [NUM_CH-1:0][DATA_W-1:0] cur_v;
    logic [NUM_CH-1:0][DATA_W-1:0] bite_v;
    logic [NUM_CH-1:0][DATA_W-1:0] bark_v;
    logic [NUM_CH-1:0][DATA_W-1:0] ctrl_v;
    logic [NUM_CH-1:0]            req_v;
    logic [NUM_CH-1:0]            irq_v;

    wdt_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
        .addr_i (bus_addr_i),
        .hit_o  (hit),
        .ch_o   (ch_sel),
        .fld_o  (fld_sel)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic sel;
            assign sel = bus_we_i && hit && (ch_sel == CHW'(g));

            wdt_chan #(.DW(DATA_W), .HAS_BARK(g == 0)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_i    (tick_i),
                .wr_cur_i  (sel && (fld_sel == FLD_CUR)),
                .wr_bite_i (sel && (fld_sel == FLD_BITE)),
                .wr_bark_i (sel && (fld_sel == FLD_BARK)),
                .wr_ctrl_i (sel && (fld_sel == FLD_CTRL)),
                .wdata_i   (bus_wdata_i),
                .cur_o     (cur_v[g]),
                .bite_o    (bite_v[g]),
                .bark_o    (bark_v[g]),
                .ctrl_o    (ctrl_v[g]),
                .rst_req_o (req_v[g]),
                .irq_o     (irq_v[g])
            );
        end
    endgenerate

    wdt_rdmux #(.DW(DATA_W), .NUM_CH(NUM_CH)) u_rdmux (
        .hit_i   (hit),
        .ch_i    (ch_sel),
        .fld_i   (fld_sel),
        .cur_i   (cur_v),
        .bite_i  (bite_v),
        .bark_i  (bark_v),
        .ctrl_i  (ctrl_v),
        .rdata_o (bus_rdata_o)
    );

    always_comb begin
        irq_o          = irq_v[0];
        rst_recovery_o = req_v[0];
        rst_system_o   = 1'b0;
        for (int i = 1; i < NUM_CH; i++) begin
            rst_system_o = rst_system_o | req_v[i];
        end
    end

    a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata_o == '0));
    a_r4_channel_routing: assert property (@(posedge clk) disable iff (!rst_n)
        rst_system_o |-> (|req_v[NUM_CH-1:1]));

endmodule

// File: tb/tb_wdt_triple.sv
`timescale 1ns/1ps
module tb_wdt_triple;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_rec;
    logic        rst_sys;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    wdt_triple dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .bus_we_i       (we),
        .bus_addr_i     (addr),
        .bus_wdata_i    (wdata),
        .bus_rdata_o    (rdata),
        .irq_o          (irq),
        .rst_recovery_o (rst_rec),
        .rst_system_o   (rst_sys)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [7:0] regs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h20, 8'h24, 8'h2C};
        for (int i = 0; i < 10; i++) begin
            bus_read(regs[i], v);
            check("R1 register zero after reset", v, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);
        check("R1 recovery low", {31'b0, rst_rec}, 32'h0);
        check("R1 system low", {31'b0, rst_sys}, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        bus_write(8'h10, 32'd100);
        bus_read(8'h10, v);  check("R9 ch1 counter readback", v, 32'd100);
        idle(); idle(); idle();
        bus_read(8'h10, v);  check("R2 no tick holds", v, 32'd100);
        ticks(4);
        bus_read(8'h10, v);  check("R2 four ticks", v, 32'd104);
        bus_write(8'h10, 32'hFFFF_FFFF);
        ticks(1);
        bus_read(8'h10, v);  check("R2 wrap to zero", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk);
        we = 1'b1; addr = 8'h20; wdata = 32'd55; tick = 1'b1;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
        bus_read(8'h20, v);  check("R3 write beats tick", v, 32'd55);
    endtask

    task automatic t_bite_threshold();
        logic [31:0] v;
        bus_write(8'h14, 32'd10);
        bus_write(8'h10, 32'd8);
        bus_write(8'h1C, 32'd4);
        idle();
        check("R4 below bite quiet", {31'b0, rst_sys}, 32'h0);
        ticks(1); idle();
        check("R4 one below bite quiet", {31'b0, rst_sys}, 32'h0);
        ticks(1); idle();
        check("R4 equal bite requests system", {31'b0, rst_sys}, 32'h1);
        check("R4 ch1 not on recovery", {31'b0, rst_rec}, 32'h0);
        bus_write(8'h1C, 32'd0); idle();
        check("R5 disarm drops request", {31'b0, rst_sys}, 32'h0);
        bus_read(8'h10, v);  check("R5 counter kept", v, 32'd10);
        ticks(1);
        bus_read(8'h10, v);  check("R5 counter still runs", v, 32'd11);
    endtask

    task automatic t_immediate();
        logic [31:0] v;
        bus_write(8'h0C, 32'd4);
        bus_write(8'h04, 32'd0);
        bus_write(8'h00, 32'd0);
        idle();
        check("R6 immediate recovery request", {31'b0, rst_rec}, 32'h1);
        check("R4 ch0 not on system", {31'b0, rst_sys}, 32'h0);
        bus_write(8'h0C, 32'd0); idle();
        check("R5 ch0 disarm", {31'b0, rst_rec}, 32'h0);
        bus_write(8'h2C, 32'd4); idle();
        check("R4 ch2 drives system", {31'b0, rst_sys}, 32'h1);
        bus_write(8'h2C, 32'd7);
        bus_read(8'h2C, v);  check("R9 ch2 ctrl low bits read zero", v, 32'd4);
        bus_write(8'h2C, 32'd0); idle();
        check("R5 ch2 disarm", {31'b0, rst_sys}, 32'h0);
    endtask

    task automatic t_bark();
        logic [31:0] v;
        bus_write(8'h08, 32'd5);
        bus_read(8'h08, v);  check("R9 bark readback", v, 32'd5);
        bus_write(8'h00, 32'd0);
        bus_write(8'h0C, 32'd1);
        idle();
        check("R7 no irq below bark", {31'b0, irq}, 32'h0);
        ticks(4); idle();
        bus_read(8'h0C, v);  check("R7 one below bark no status", v, 32'd1);
        ticks(1); idle();
        check("R7 irq at bark", {31'b0, irq}, 32'h1);
        bus_read(8'h0C, v);  check("R7 status set", v, 32'd3);
        bus_write(8'h00, 32'd0); idle();
        check("R7 irq sticky after service", {31'b0, irq}, 32'h1);
        bus_write(8'h0C, 32'd1);
        bus_read(8'h0C, v);  check("R8 write zero keeps status", v, 32'd3);
        bus_write(8'h0C, 32'd3);
        bus_read(8'h0C, v);  check("R8 write one clears status", v, 32'd1);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
        bus_write(8'h00, 32'd5); idle();
        check("R7 irq again", {31'b0, irq}, 32'h1);
        bus_write(8'h0C, 32'd0);
        check("R7 irq masked by enable", {31'b0, irq}, 32'h0);
        bus_read(8'h0C, v);  check("R7 status kept while masked", v, 32'd2);
        bus_write(8'h0C, 32'd2);
        bus_read(8'h0C, v);  check("R8 clear while disabled", v, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(8'h18, 32'hABCD_1234);
        bus_write(8'h28, 32'h1357_9BDF);
        bus_write(8'h34, 32'h0000_00FF);
        bus_read(8'h18, v);  check("R10 read 0x18 zero", v, 32'h0);
        bus_read(8'h28, v);  check("R10 read 0x28 zero", v, 32'h0);
        bus_read(8'h30, v);  check("R10 read 0x30 zero", v, 32'h0);
        bus_read(8'h02, v);  check("R10 unaligned read zero", v, 32'h0);
        bus_read(8'h14, v);  check("R10 ch1 bite untouched", v, 32'd10);
        bus_read(8'h24, v);  check("R10 ch2 bite untouched", v, 32'd0);
        bus_read(8'h08, v);  check("R10 ch0 bark untouched", v, 32'd5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_collide();
        t_bite_threshold();
        t_immediate();
        t_bark();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule